// File: doc/BRIEF.md
# Deadtimeless Delay-Line TDC Time-Sensing Front End

This block turns a per-clock picture of a tapped delay line into timestamped hit records. Each system clock it receives a registered snapshot of the tap sampling registers. Tap 0 sits nearest the input, and later taps see the input later. The block compares the reference tap with its value in the previous snapshot to find out whether the input changed level during the cycle. When it did, the block encodes how far the new level has travelled along the taps. That distance is the fine time, at one tap per 15.625 ps by default. The block tags the record with a free-running binary coarse count, one count per clock (4 ns at 250 MHz), and with the direction of the edge.

The hit input reaches the logic only as data inside the snapshot, and every register runs on the one system clock. A single capture stage and a single encoder serve both edge directions. The captured snapshot is simply overwritten on each clock and is never cleared between events. The pipeline accepts a new hit on every clock, so back-to-back transitions in consecutive cycles each produce their own record.

Top module: `tdc_time_front`

## Requirements
- R1: While reset is high and on the first clock after it, `hit_valid_o` is 0 and `fine_o`, `coarse_o` and `hit_rise_o` are 0. The internal previous-level reference resets to 0.
- R2: The coarse counter is 0 at the first clock edge after reset is released and then increments by one per clock, wrapping modulo 2^COARSE_W.
- R3: `hit_valid_o` is 1 exactly for the snapshots whose tap 0 differs from tap 0 of the snapshot captured one clock earlier.
- R4: `hit_rise_o` is the new level of tap 0 for a valid hit: 1 for a rising edge and 0 for a falling edge.
- R5: `fine_o` is the smallest index i, with 1 <= i <= TAPS-1, at which tap i holds the old level and either tap i+1 also holds the old level or i equals TAPS-1. A single tap at the old level followed by a tap at the new level is treated as a bubble and skipped.
- R6: When no index satisfies R5 because all taps hold the new level, `fine_o` saturates at TAPS-1.
- R7: Hits in consecutive clocks each produce a valid record, with no dead cycle between them.
- R8: A record appears two clock edges after its snapshot is presented. Its `coarse_o` equals the counter value at the edge where that snapshot was captured.
- R9: While `hit_valid_o` is 0, `fine_o`, `coarse_o` and `hit_rise_o` keep the values of the last valid record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | TAPS | Registered delay-line snapshot, bit 0 = tap nearest the input |
| hit_valid_o | output | 1 | One-clock strobe marking a new hit record |
| hit_rise_o | output | 1 | Edge direction of the record (1 rising, 0 falling) |
| fine_o | output | $clog2(TAPS) | Encoded tap position of the transition |
| coarse_o | output | COARSE_W | Coarse clock count at capture |

## Verification
A snapshot driven before clock edge k is captured at edge k, and its record is registered at edge k+1. The bench therefore drives inputs at the falling edge. It holds each expected record in a two-deep queue and compares the record against the outputs at the falling edge two cycles later. The expected coarse value is the number of non-reset edges seen before the snapshot was driven, reduced modulo 2^COARSE_W. In cycles with no record, the bench checks that the outputs still hold the last record.

// File: rtl/tdc_fe_pkg.sv
package tdc_fe_pkg;

    localparam int DEF_TAPS     = 256;  // 4 ns / 15.625 ps
    localparam int DEF_COARSE_W = 16;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    function automatic int fine_bits(input int taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst) count_o <= '0;
        else     count_o <= count_o + 1'b1;
    end

    // R2: one step per clock, wrapping
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_o == W'($past(count_o) + 1'b1));
endmodule

// File: rtl/tdc_snap_stage.sv
module tdc_snap_stage #(
    parameter int TAPS     = 256,
    parameter int COARSE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TAPS-1:0]     samp_i,
    input  logic [COARSE_W-1:0] count_i,
    output logic [TAPS-1:0]     snap_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic                hit_o,
    output logic                level_o
);
    logic ref_prev;

    // Snapshot and its coarse stamp are taken at the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_o   <= '0;
            coarse_o <= '0;
            ref_prev <= 1'b0;
        end else begin
            snap_o   <= samp_i;
            coarse_o <= count_i;
            ref_prev <= snap_o[0];
        end
    end

    always_comb begin
        level_o = snap_o[0];
        hit_o   = snap_o[0] ^ ref_prev;
    end
endmodule

// File: rtl/tdc_fine_enc.sv
module tdc_fine_enc #(
    parameter int TAPS = 256,
    localparam int FW  = tdc_fe_pkg::fine_bits(TAPS)
) (
    input  logic [TAPS-1:0] snap_i,
    input  logic            level_i,
    output logic [FW-1:0]   fine_o
);
    logic [TAPS:0] ext;
    logic          found;

    always_comb begin
        ext    = {~level_i, snap_i};
        fine_o = FW'(TAPS - 1);
        found  = 1'b0;
        for (int i = 1; i < TAPS; i++) begin
            if (!found && (ext[i] != level_i) && (ext[i+1] != level_i)) begin
                fine_o = FW'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdc_time_front.sv
module tdc_time_front
    import tdc_fe_pkg::*;
#(
    parameter int TAPS     = DEF_TAPS,
    parameter int COARSE_W = DEF_COARSE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [TAPS-1:0]           samp_i,
    output logic                      hit_valid_o,
    output logic                      hit_rise_o,
    output logic [$clog2(TAPS)-1:0]   fine_o,
    output logic [COARSE_W-1:0]       coarse_o
);
    localparam int FW = fine_bits(TAPS);

    logic [COARSE_W-1:0] count;
    logic [TAPS-1:0]     snap;
    logic [COARSE_W-1:0] snap_coarse;
    logic                hit;
    logic                level;
    logic [FW-1:0]       fine_enc;
    edge_kind_e          kind;

    tdc_coarse_ctr #(.W(COARSE_W)) u_ctr (
        .clk(clk), .rst(rst), .count_o(count)
    );

    tdc_snap_stage #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_snap (
        .clk(clk), .rst(rst), .samp_i(samp_i), .count_i(count),
        .snap_o(snap), .coarse_o(snap_coarse), .hit_o(hit), .level_o(level)
    );

    tdc_fine_enc #(.TAPS(TAPS)) u_enc (
        .snap_i(snap), .level_i(level), .fine_o(fine_enc)
    );

    always_comb kind = level ? EDGE_RISE : EDGE_FALL;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid_o <= 1'b0;
            hit_rise_o  <= 1'b0;
            fine_o      <= '0;
            coarse_o    <= '0;
        end else begin
            hit_valid_o <= hit;
            if (hit) begin
                hit_rise_o <= (kind == EDGE_RISE);
                fine_o     <= fine_enc;
                coarse_o   <= snap_coarse;
            end
        end
    end

    // R9: record fields hold while no hit is reported
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !hit_valid_o |-> ($stable(fine_o) && $stable(coarse_o) && $stable(hit_rise_o)));

    // R4: consecutive-cycle records alternate direction
    a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
        (hit_valid_o && $past(hit_valid_o)) |-> (hit_rise_o != $past(hit_rise_o)));

    // R8: consecutive-cycle records carry coarse stamps one apart
    a_r8_coarse_step: assert property (@(posedge clk) disable iff (rst)
        (hit_valid_o && $past(hit_valid_o)) |-> coarse_o == COARSE_W'($past(coarse_o) + 1'b1));

    // R5: the encoded tap holds the old level, unless saturated (R6)
    a_r5_fine_tap: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((snap[fine_enc] != level) || (fine_enc == FW'(TAPS - 1))));
endmodule

// File: tb/tb_tdc_time_front.sv
module tb_tdc_time_front;
    localparam int  TAPS   = 64;
    localparam int  CW     = 8;
    localparam int  FW     = $clog2(TAPS);
    localparam time CLK_PERIOD = 4ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [TAPS-1:0] samp = '0;
    logic            valid, rise;
    logic [FW-1:0]   fine;
    logic [CW-1:0]   coarse;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdc_time_front #(.TAPS(TAPS), .COARSE_W(CW)) dut (
        .clk(clk), .rst(rst), .samp_i(samp),
        .hit_valid_o(valid), .hit_rise_o(rise), .fine_o(fine), .coarse_o(coarse)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_fine(input logic [TAPS-1:0] s, input logic old);
        for (int i = 1; i < TAPS; i++) begin
            if (s[i] == old && (i == TAPS-1 || s[i+1] == old)) return i;
        end
        return TAPS-1;
    endfunction

    typedef struct {
        bit v; bit r; int f; int c; bit sat; bit b2b;
    } rec_t;

    rec_t q0, q1, nw;
    logic cur_lvl;
    int   bcnt;
    int   last_f, last_c;
    bit   last_r;

    initial begin
        void'($urandom(32'd4242));
        q0 = '{default:0}; q1 = '{default:0};
        cur_lvl = 1'b0; bcnt = 0; last_f = 0; last_c = 0; last_r = 0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 valid", valid, 0);
            check("R1 fine", fine, 0);
            check("R1 coarse", coarse, 0);
        end
        rst = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            int  k, p, b;
            bit  hit, bub;
            logic nl;
            if (n > 0) @(negedge clk);
            // compare the record due from two cycles back
            check(q1.b2b ? "R7 R3 valid" : "R3 R8 valid", valid, q1.v);
            if (q1.v) begin
                check(q1.sat ? "R6 fine" : "R5 fine", fine, q1.f);
                check("R2 R8 coarse", coarse, q1.c);
                check("R4 polarity", rise, q1.r);
                last_f = q1.f; last_c = q1.c; last_r = q1.r;
            end else begin
                check("R9 hold fine", fine, last_f);
                check("R9 hold coarse", coarse, last_c);
                check("R9 hold polarity", rise, last_r);
            end
            // next stimulus: directed corners first, then random
            k = $urandom_range(0, 9);
            p = $urandom_range(1, TAPS-1);
            bub = ($urandom_range(0, 2) == 0);
            if (n < 8) begin
                hit = 1; bub = 0;
                p = (n == 0) ? 1 : (n == 1) ? TAPS : (n == 2) ? TAPS-1 : n * 5;
            end else if (n < 12) begin
                hit = 0;
            end else begin
                hit = (k >= 4);
                if (k == 9) p = TAPS;
            end
            nl = hit ? ~cur_lvl : cur_lvl;
            for (int i = 0; i < TAPS; i++) samp[i] = (i < p) ? nl : cur_lvl;
            if (hit && bub && p >= 4) begin
                b = $urandom_range(1, p-3);
                samp[b] = cur_lvl;
            end
            nw.v   = hit;
            nw.r   = nl;
            nw.f   = hit ? exp_fine(samp, cur_lvl) : 0;
            nw.sat = hit && (p == TAPS);
            nw.c   = bcnt % (1 << CW);
            nw.b2b = hit && q0.v;
            q1 = q0; q0 = nw;
            cur_lvl = nl;
            bcnt++;
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule